// File: doc/BRIEF.md
# LAPS Frame Encapsulator (Byte-Stuffed, Scrambled)

This block turns a stream of packet bytes into LAPS-style frames on a byte-wide output stream. A frame opens with a 0x7E flag. Four header octets follow: a programmable address byte, a programmable control byte and a programmable two-byte protocol identifier. The scrambled packet bytes come next, then a 32-bit frame check sequence and a closing 0x7E flag. Packets enter through a ready/valid port, and the last byte of a packet is marked. Frames leave through a ready/valid port whose data and valid come straight from registers.

The information field is scrambled by a self-synchronising x^43+1 scrambler. The scrambler keeps its state from one frame to the next. Escaping for transparency is done after scrambling and after the check sequence is computed. Every 0x7E or 0x7D octet between the two flags is sent as two bytes, so the flags stay unique on the line. While the second byte of an escape pair is waiting, the block stops taking input.

Top module: `laps_encap`

## Requirements
- R1: While reset is high and in the first cycle after it falls, out_valid and in_ready are both 0.
- R2: Each frame starts and ends with one unescaped 0x7E flag. A frame begins only after a packet byte is offered.
- R3: The four octets after the opening flag are cfg_addr, cfg_ctrl, cfg_sapi[15:8] and cfg_sapi[7:0], in that order.
- R4: Each payload byte is scrambled LSB first. Each output bit is the input bit XOR the scrambled bit 43 positions earlier. The scrambler history is zero after reset, only payload bits enter it, and it carries over between frames.
- R5: After the payload come four check octets, least significant octet first. They are the complement of a reflected CRC-32 (polynomial 0xEDB88320, preset 0xFFFFFFFF) taken over the header octets and the unscrambled payload. They are not scrambled.
- R6: A 0x7E octet between the flags goes out as 0x7D followed by 0x5E.
- R7: A 0x7D octet between the flags goes out as 0x7D followed by 0x5D.
- R8: in_ready is 0 in every cycle in which the output register holds the 0x7D lead byte of an escape pair.
- R9: While out_valid is 1 and out_ready is 0, out_valid stays 1 and out_data does not change in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_addr | input | 8 | Address octet placed in the header |
| cfg_ctrl | input | 8 | Control octet placed in the header |
| cfg_sapi | input | 16 | Protocol identifier, high octet sent first |
| in_data | input | 8 | Packet byte |
| in_valid | input | 1 | Packet byte present |
| in_last | input | 1 | Marks the final byte of a packet |
| in_ready | output | 1 | Block takes the packet byte this cycle |
| out_data | output | 8 | Frame byte |
| out_valid | output | 1 | Frame byte present |
| out_ready | input | 1 | Sink takes the frame byte |

## Verification
A byte accepted by the framing stage is in the output register one clock later. The second byte of an escape pair follows in the next free output slot. The bench therefore does not compute cycle offsets. It changes inputs at the falling edge, waits 1 ns, and then treats the output byte as transferred only if out_valid and out_ready are both high at that point. That byte is compared in order against a stream built from the requirements by a bench model of the scrambler and CRC. The stall hold (R9) and the blocked input during escape (R8) are checked in the same sampling slot, against the values seen one cycle earlier.

// File: rtl/laps_pkg.sv
package laps_pkg;
  localparam logic [7:0] FLAG_OCT = 8'h7E;
  localparam logic [7:0] ESC_OCT  = 8'h7D;
  localparam logic [7:0] ESC_FLIP = 8'h20;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_CTRL, ST_SAPH, ST_SAPL, ST_PAY, ST_FCS, ST_CLOSE
  } enc_state_t;

  function automatic logic [31:0] crc_step(input logic [31:0] crc,
                                           input logic [7:0] d,
                                           input logic [31:0] poly);
    logic [31:0] c;
    c = crc ^ {24'd0, d};
    for (int k = 0; k < 8; k++)
      c = c[0] ? ((c >> 1) ^ poly) : (c >> 1);
    return c;
  endfunction
endpackage

// File: rtl/laps_scrambler.sv
module laps_scrambler #(
  parameter int LAG = 43,
  parameter int W   = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [LAG-1:0] hist_q, hist_n;

  always_comb begin
    hist_n = hist_q;
    dout   = '0;
    for (int i = 0; i < W; i++) begin
      dout[i] = din[i] ^ hist_n[LAG-1];
      hist_n  = {hist_n[LAG-2:0], dout[i]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst)       hist_q <= '0;
    else if (step) hist_q <= hist_n;
  end
endmodule

// File: rtl/laps_fcs.sv
module laps_fcs #(
  parameter logic [31:0] POLY = 32'hEDB88320,
  parameter logic [31:0] INIT = 32'hFFFFFFFF
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        clear,
  input  logic        step,
  input  logic [7:0]  din,
  output logic [31:0] crc_q
);
  always_ff @(posedge clk) begin
    if (rst || clear) crc_q <= INIT;
    else if (step)    crc_q <= laps_pkg::crc_step(crc_q, din, POLY);
  end
endmodule

// File: rtl/laps_escaper.sv
module laps_escaper (
  input  logic       clk,
  input  logic       rst,
  input  logic       raw_valid,
  input  logic [7:0] raw_data,
  input  logic       raw_flag,
  output logic       raw_ready,
  input  logic       out_ready,
  output logic       out_valid,
  output logic [7:0] out_data,
  output logic       pend
);
  import laps_pkg::*;

  logic       slot_free;
  logic [7:0] pend_byte;
  logic       needs_esc;

  assign slot_free = !out_valid || out_ready;
  assign raw_ready = slot_free && !pend;
  assign needs_esc = !raw_flag && (raw_data == FLAG_OCT || raw_data == ESC_OCT);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      pend      <= 1'b0;
      pend_byte <= '0;
    end else if (slot_free) begin
      if (pend) begin
        out_data  <= pend_byte;
        out_valid <= 1'b1;
        pend      <= 1'b0;
      end else if (raw_valid) begin
        out_valid <= 1'b1;
        if (needs_esc) begin
          out_data  <= ESC_OCT;
          pend      <= 1'b1;
          pend_byte <= raw_data ^ ESC_FLIP;
        end else begin
          out_data <= raw_data;
        end
      end else begin
        out_valid <= 1'b0;
      end
    end
  end

  assert_esc_lead_R6: assert property (@(posedge clk) disable iff (rst)
    pend |-> (out_valid && out_data == ESC_OCT));

  assert_esc_second_R7: assert property (@(posedge clk) disable iff (rst)
    (pend && out_ready) |=> (out_valid && (out_data == 8'h5E || out_data == 8'h5D)));

  assert_out_stable_R9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

// File: rtl/laps_encap.sv
module laps_encap #(
  parameter int          SCR_LAG   = 43,
  parameter logic [31:0] CRC_POLY  = 32'hEDB88320,
  parameter int          FCS_BYTES = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [7:0]  cfg_addr,
  input  logic [7:0]  cfg_ctrl,
  input  logic [15:0] cfg_sapi,
  input  logic [7:0]  in_data,
  input  logic        in_valid,
  input  logic        in_last,
  output logic        in_ready,
  output logic [7:0]  out_data,
  output logic        out_valid,
  input  logic        out_ready
);
  import laps_pkg::*;

  localparam int IDX_W = (FCS_BYTES > 1) ? $clog2(FCS_BYTES) : 1;

  enc_state_t       state_q;
  logic [IDX_W-1:0] fcs_idx_q;
  logic             raw_valid, raw_flag, raw_ready, fire, pend;
  logic [7:0]       raw_data, scr_byte, fcs_din;
  logic [31:0]      crc_q;
  logic             fcs_step, fcs_clear, scr_step, in_hdr;

  laps_scrambler #(.LAG(SCR_LAG), .W(8)) u_scr (
    .clk(clk), .rst(rst), .step(scr_step), .din(in_data), .dout(scr_byte)
  );

  laps_fcs #(.POLY(CRC_POLY)) u_fcs (
    .clk(clk), .rst(rst), .clear(fcs_clear), .step(fcs_step),
    .din(fcs_din), .crc_q(crc_q)
  );

  laps_escaper u_esc (
    .clk(clk), .rst(rst), .raw_valid(raw_valid), .raw_data(raw_data),
    .raw_flag(raw_flag), .raw_ready(raw_ready), .out_ready(out_ready),
    .out_valid(out_valid), .out_data(out_data), .pend(pend)
  );

  always_comb begin
    raw_valid = 1'b1;
    raw_flag  = 1'b0;
    raw_data  = '0;
    case (state_q)
      ST_IDLE:  begin raw_valid = in_valid; raw_flag = 1'b1; raw_data = FLAG_OCT; end
      ST_ADDR:  raw_data = cfg_addr;
      ST_CTRL:  raw_data = cfg_ctrl;
      ST_SAPH:  raw_data = cfg_sapi[15:8];
      ST_SAPL:  raw_data = cfg_sapi[7:0];
      ST_PAY:   begin raw_valid = in_valid; raw_data = scr_byte; end
      ST_FCS:   raw_data = ~crc_q[8*fcs_idx_q +: 8];
      default:  begin raw_flag = 1'b1; raw_data = FLAG_OCT; end
    endcase
  end

  assign fire      = raw_valid && raw_ready;
  assign in_ready  = (state_q == ST_PAY) && raw_ready;
  assign in_hdr    = (state_q == ST_ADDR) || (state_q == ST_CTRL) ||
                     (state_q == ST_SAPH) || (state_q == ST_SAPL);
  assign fcs_clear = fire && (state_q == ST_IDLE);
  assign fcs_step  = fire && (in_hdr || state_q == ST_PAY);
  assign fcs_din   = (state_q == ST_PAY) ? in_data : raw_data;
  assign scr_step  = fire && (state_q == ST_PAY);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      fcs_idx_q <= '0;
    end else if (fire) begin
      case (state_q)
        ST_IDLE: state_q <= ST_ADDR;
        ST_ADDR: state_q <= ST_CTRL;
        ST_CTRL: state_q <= ST_SAPH;
        ST_SAPH: state_q <= ST_SAPL;
        ST_SAPL: state_q <= ST_PAY;
        ST_PAY: if (in_last) begin
          state_q   <= ST_FCS;
          fcs_idx_q <= '0;
        end
        ST_FCS: begin
          if (fcs_idx_q == IDX_W'(FCS_BYTES - 1)) state_q <= ST_CLOSE;
          fcs_idx_q <= fcs_idx_q + 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_valid && !in_ready));

  assert_open_flag_R2: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE && fire) |=> (out_valid && out_data == FLAG_OCT && state_q == ST_ADDR));

  assert_hdr_no_input_R3: assert property (@(posedge clk) disable iff (rst)
    in_hdr |-> !in_ready);

  assert_esc_blocks_input_R8: assert property (@(posedge clk) disable iff (rst)
    pend |-> !in_ready);
endmodule

// File: tb/test_laps_encap.sv
`timescale 1ns/1ps
module test_laps_encap;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  cfg_addr = 8'h00, cfg_ctrl = 8'h00;
  logic [15:0] cfg_sapi = 16'h0000;
  logic [7:0]  in_data = 8'h00;
  logic        in_valid = 1'b0, in_last = 1'b0;
  logic        in_ready;
  logic [7:0]  out_data;
  logic        out_valid;
  logic        out_ready = 1'b0;

  always #4 clk = ~clk;

  laps_encap i_laps_encap (
    .clk(clk), .rst(rst), .cfg_addr(cfg_addr), .cfg_ctrl(cfg_ctrl),
    .cfg_sapi(cfg_sapi), .in_data(in_data), .in_valid(in_valid),
    .in_last(in_last), .in_ready(in_ready), .out_data(out_data),
    .out_valid(out_valid), .out_ready(out_ready)
  );

  int total = 0, fails = 0, cyc = 0;
  bit running = 1'b0, backpressure = 1'b0, done = 1'b0;
  bit prev_stall = 1'b0;
  logic [7:0] prev_data = 8'h00;

  logic [7:0] q_in[$];
  bit         q_last[$];
  logic [7:0] q_exp[$];
  int         q_tag[$];
  logic [42:0] m_hist = '0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic string tag_req(input int t);
    case (t)
      2: return "R2 flag";
      3: return "R3 header";
      4: return "R4 payload";
      5: return "R5 fcs";
      6: return "R6 second byte";
      7: return "R7 second byte";
      default: return "R6 R7 escape lead";
    endcase
  endfunction

  function automatic logic [31:0] m_crc(input logic [31:0] c0, input logic [7:0] d);
    logic [31:0] c;
    c = c0 ^ {24'd0, d};
    for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    return c;
  endfunction

  task automatic push_enc(input logic [7:0] b, input int tag);
    if (b == 8'h7E || b == 8'h7D) begin
      q_exp.push_back(8'h7D); q_tag.push_back(8);
      q_exp.push_back(b ^ 8'h20); q_tag.push_back((b == 8'h7E) ? 6 : 7);
    end else begin
      q_exp.push_back(b); q_tag.push_back(tag);
    end
  endtask

  task automatic add_frame(input int len, input int seed, input bit esc_heavy);
    logic [31:0] crc;
    logic [7:0]  hdr[4];
    logic [7:0]  p, s;
    crc = 32'hFFFFFFFF;
    hdr[0] = cfg_addr; hdr[1] = cfg_ctrl; hdr[2] = cfg_sapi[15:8]; hdr[3] = cfg_sapi[7:0];
    q_exp.push_back(8'h7E); q_tag.push_back(2);
    for (int h = 0; h < 4; h++) begin
      crc = m_crc(crc, hdr[h]);
      push_enc(hdr[h], 3);
    end
    for (int i = 0; i < len; i++) begin
      if (esc_heavy) p = (i % 3 == 0) ? 8'h7E : ((i % 3 == 1) ? 8'h7D : 8'h00);
      else p = 8'((seed * 29 + i * 71 + i * i) & 255);
      crc = m_crc(crc, p);
      for (int b = 0; b < 8; b++) begin
        s[b] = p[b] ^ m_hist[42];
        m_hist = {m_hist[41:0], s[b]};
      end
      q_in.push_back(p); q_last.push_back(i == len - 1);
      push_enc(s, 4);
    end
    crc = ~crc;
    for (int k = 0; k < 4; k++) push_enc(crc[8*k +: 8], 5);
    q_exp.push_back(8'h7E); q_tag.push_back(2);
  endtask

  always @(negedge clk) begin
    if (running) begin
      cyc++;
      out_ready = backpressure ? ((cyc % 5) != 3 && (cyc % 7) != 1) : 1'b1;
      if (!(in_valid && !in_ready_seen_hold())) begin
        in_valid = (q_in.size() > 0) && ((cyc % 7) != 2);
      end
      if (q_in.size() > 0) begin
        in_data = q_in[0];
        in_last = q_last[0];
      end else begin
        in_valid = 1'b0;
      end
      #1;
      if (prev_stall)
        chk(out_valid && out_data == prev_data, "R9 stall hold", {23'd0, out_valid, out_data}, {24'd1, prev_data});
      prev_stall = out_valid && !out_ready;
      prev_data  = out_data;
      if (out_valid && q_tag.size() > 0 && q_tag[0] == 8)
        chk(in_ready == 1'b0, "R8 input blocked on escape", in_ready, 0);
      if (out_valid && out_ready) begin
        if (q_exp.size() == 0) chk(1'b0, "R2 extra output byte", out_data, 0);
        else begin
          chk(out_data == q_exp[0], tag_req(q_tag[0]), out_data, q_exp[0]);
          void'(q_exp.pop_front());
          void'(q_tag.pop_front());
        end
      end
      accepted_last = in_valid && in_ready;
      if (in_valid && in_ready) begin
        void'(q_in.pop_front());
        void'(q_last.pop_front());
      end
      if (cyc > 100000 && !done) begin
        chk(1'b0, "watchdog", cyc, 100000);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
      end
    end
  end

  bit accepted_last = 1'b1;
  function automatic bit in_ready_seen_hold();
    return accepted_last;
  endfunction

  task automatic run_phase(input logic [7:0] a, input logic [7:0] c, input logic [15:0] sp,
                           input bit bp, input int nfr);
    cfg_addr = a; cfg_ctrl = c; cfg_sapi = sp; backpressure = bp;
    for (int f = 1; f <= nfr; f++) add_frame(f, f + 3 * a, 1'b0);
    add_frame(9, 0, 1'b1);
    running = 1'b1;
    wait (q_exp.size() == 0 && q_in.size() == 0);
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(out_valid == 1'b0 && in_ready == 1'b0, "R1 during reset", {out_valid, in_ready}, 0);
    rst = 1'b0;
    @(negedge clk);
    #1;
    chk(out_valid == 1'b0 && in_ready == 1'b0, "R1 after reset", {out_valid, in_ready}, 0);
    repeat (4) @(negedge clk);
    chk(out_valid == 1'b0, "R2 no frame without input", out_valid, 0);
    run_phase(8'h04, 8'h03, 16'hFE01, 1'b0, 16);
    run_phase(8'h7E, 8'h7D, 16'h7D7E, 1'b1, 16);
    run_phase(8'hFF, 8'h13, 16'h0021, 1'b1, 6);
    done = 1'b1;
    chk(q_exp.size() == 0 && q_in.size() == 0, "R2 stream complete", q_exp.size(), 0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule